// File: doc/BRIEF.md
# Link-Event LED Controller

This block drives a small set of status LEDs for a multi-rate Ethernet port. Every LED has two independent event masks. A steady mask lights the LED whenever a selected link condition holds: link down, link up at 100M, at 1G or at 2.5G, or a forced-on bit. A blink mask makes the LED flash when any selected traffic pulse arrives: transmit or receive activity at each of the three speeds, or a forced-blink bit. A steady condition always overrides blinking.

All LEDs share one blink waveform. A prescaled tick advances a phase counter through a programmable period, and the LED is lit during the first part of that period, for a programmable number of ticks. A global control register grants external control, selects the operating mode and gates the tick source. Per-LED registers hold an enable bit and a polarity bit, so active-low and active-high drivers can share the same logic. Software programs everything through a flat address/data port with a combinational read path.

Top module: `lnk_led_ctrl`

## Requirements
- R1: The register port decodes global control at 0x21, on-time at 0x22, blink period at 0x23, and for LED i the steady-mask register at 0x24+2i and the blink-mask register at 0x25+2i. Read-back returns the written value ANDed with a field mask: 0x800B for global control, 0xC14B for steady registers, 0x0E0F for blink registers, and all 16 bits for on-time and period. Unmapped addresses read 0.
- R2: After reset, every register reads 0 and every LED output is 1, which is the inactive level for polarity 0.
- R3: An LED output leaves its inactive level only while global control bit 15 is set and global control bits [1:0] are non-zero. In any other state, the output rests at its inactive level.
- R4: In the steady register, bit 15 enables the LED and bit 14 sets polarity (1 = active high, so lit drives 1; 0 = active low, so lit drives 0). A disabled LED rests at its inactive level.
- R5: The steady mask lights the LED when any selected condition holds. The bits are: bit 8 = link up at 2.5G, bit 6 = forced on, bit 3 = link down, bit 1 = link up at 100M, bit 0 = link up at 1G. link_speed encodes 00 = 100M, 01 = 1G, 10 = 2.5G and 11 = none.
- R6: A true steady condition keeps the LED lit continuously, even while a blink condition is active.
- R7: While blinking, the LED is lit for on-time ticks out of every period ticks. An on-time of at least the period gives a continuously lit LED. An on-time of 0 never lights it.
- R8: One tick occurs every PRESCALE clock cycles, and only while global control bit 3 is set. While bit 3 is clear, the blink phase is frozen and the LED does not toggle.
- R9: The blink mask selects the activity sources. The bits are: bit 11 = 2.5G receive, bit 10 = 2.5G transmit, bit 9 = forced blink, bit 3 = 100M receive, bit 2 = 100M transmit, bit 1 = 1G receive, bit 0 = 1G transmit. Activity bits are indexed by speed: [0] = 100M, [1] = 1G, [2] = 2.5G. A pulse on an unselected source does not light the LED.
- R10: A single-cycle activity pulse keeps the LED blinking for at least one full blink period. The blinking stops within two periods after the pulse.
- R11: The LED output is registered. It reflects the inputs and registers with one clock of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| link_up | input | 1 | Link status |
| link_speed | input | 2 | Resolved speed: 00 100M, 01 1G, 10 2.5G, 11 none |
| act_tx | input | 3 | Transmit activity pulses by speed |
| act_rx | input | 3 | Receive activity pulses by speed |
| led_o | output | N_LED | LED drive outputs |

## Verification
The bench sweeps every steady-mask bit against every link state on all three LEDs at once, with mixed polarities. A decoder that swapped speed codes or inverted polarity on one LED would therefore light the wrong LED at the wrong rate. The blink waveform is measured by counting lit cycles over whole periods, including the corner cases where on-time is zero or exceeds the period. A wrong prescale, an off-by-one period wrap or a missing tick gate would change the count. After a single activity pulse, the bench requires exactly half of the next sixteen cycles to be lit and the LED to be dark afterwards. A hold that ends at the first wrap, or one that never clears, fails one of these two windows.

// File: rtl/lel_pkg.sv
package lel_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] ADR_CTL   = 8'h21;
    localparam logic [ADDR_W-1:0] ADR_ONT   = 8'h22;
    localparam logic [ADDR_W-1:0] ADR_PER   = 8'h23;
    localparam logic [ADDR_W-1:0] ADR_LANE0 = 8'h24;

    localparam logic [DATA_W-1:0] MSK_CTL = 16'h800B;
    localparam logic [DATA_W-1:0] MSK_ON  = 16'hC14B;
    localparam logic [DATA_W-1:0] MSK_BLK = 16'h0E0F;

    // steady register fields
    localparam int ON_EN  = 15;
    localparam int ON_POL = 14;
    localparam int EV_2G5 = 8;
    localparam int EV_FRC = 6;
    localparam int EV_DN  = 3;
    localparam int EV_100 = 1;
    localparam int EV_1G  = 0;

    // blink register fields
    localparam int BK_RX2G5 = 11;
    localparam int BK_TX2G5 = 10;
    localparam int BK_FRC   = 9;
    localparam int BK_RX100 = 3;
    localparam int BK_TX100 = 2;
    localparam int BK_RX1G  = 1;
    localparam int BK_TX1G  = 0;

    // activity vector index per speed
    localparam int SP_100 = 0;
    localparam int SP_1G  = 1;
    localparam int SP_2G5 = 2;

    typedef enum logic [1:0] {
        SPD_100M = 2'b00,
        SPD_1G   = 2'b01,
        SPD_2G5  = 2'b10,
        SPD_NONE = 2'b11
    } speed_e;
endpackage

// File: rtl/lel_regs.sv
module lel_regs
    import lel_pkg::*;
#(
    parameter int N_LED = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic                         ext_en,
    output logic [1:0]                   mode,
    output logic                         blink_en,
    output logic [DATA_W-1:0]            on_time,
    output logic [DATA_W-1:0]            period,
    output logic [N_LED-1:0][DATA_W-1:0] on_cfg,
    output logic [N_LED-1:0][DATA_W-1:0] blk_cfg
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [DATA_W-1:0]            ctl;
        logic [DATA_W-1:0]            ont;
        logic [DATA_W-1:0]            per;
        logic [N_LED-1:0][DATA_W-1:0] onc;
        logic [N_LED-1:0][DATA_W-1:0] blc;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            if (addr == ADR_CTL) r_d.ctl = wdata & MSK_CTL;
            if (addr == ADR_ONT) r_d.ont = wdata;
            if (addr == ADR_PER) r_d.per = wdata;
            for (int i = 0; i < N_LED; i++) begin
                if (addr == ADR_LANE0 + ADDR_W'(2*i))     r_d.onc[i] = wdata & MSK_ON;
                if (addr == ADR_LANE0 + ADDR_W'(2*i + 1)) r_d.blc[i] = wdata & MSK_BLK;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADR_CTL) rdata = r_q.ctl;
        if (addr == ADR_ONT) rdata = r_q.ont;
        if (addr == ADR_PER) rdata = r_q.per;
        for (int i = 0; i < N_LED; i++) begin
            if (addr == ADR_LANE0 + ADDR_W'(2*i))     rdata = r_q.onc[i];
            if (addr == ADR_LANE0 + ADDR_W'(2*i + 1)) rdata = r_q.blc[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ext_en   = r_q.ctl[15];
    assign mode     = r_q.ctl[1:0];
    assign blink_en = r_q.ctl[3];
    assign on_time  = r_q.ont;
    assign period   = r_q.per;
    assign on_cfg   = r_q.onc;
    assign blk_cfg  = r_q.blc;

    // Software-visible control takes the masked write value one cycle later.
    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_CTL) |=> ({ext_en, blink_en, mode} ==
            {$past(wdata[15]), $past(wdata[3]), $past(wdata[1:0])})); // R1
endmodule

// File: rtl/lel_timebase.sv
module lel_timebase
    import lel_pkg::*;
#(
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blink_en,
    input  logic [DATA_W-1:0] on_time,
    input  logic [DATA_W-1:0] period,
    output logic              wave,
    output logic              period_end
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [DATA_W-1:0] phase;
    } tb_t;

    tb_t t_d, t_q;
    logic tick;
    logic wrap;

    always_comb begin
        t_d  = t_q;
        tick = 1'b0;
        wrap = ({1'b0, t_q.phase} + (DATA_W+1)'(1)) >= {1'b0, period};
        if (!blink_en) begin
            t_d.pre = '0;
        end else if (t_q.pre == PRE_LAST) begin
            t_d.pre = '0;
            tick    = 1'b1;
        end else begin
            t_d.pre = t_q.pre + PRE_W'(1);
        end
        if (tick) t_d.phase = wrap ? '0 : t_q.phase + DATA_W'(1);
        wave       = t_q.phase < on_time;
        period_end = tick && wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    AST_FROZEN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_en |=> $stable(t_q.phase)); // R8
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (t_q.phase == '0)); // R7
endmodule

// File: rtl/lel_lane.sv
module lel_lane
    import lel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic [DATA_W-1:0] on_cfg,
    input  logic [DATA_W-1:0] blk_cfg,
    input  logic              link_up,
    input  speed_e            speed,
    input  logic [2:0]        act_tx,
    input  logic [2:0]        act_rx,
    input  logic              wave,
    input  logic              period_end,
    output logic              led
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic hold;
        logic armed;
        logic led;
    } lane_t;

    lane_t s_d, s_q;
    logic [DATA_W-1:0] on_ev;
    logic [DATA_W-1:0] bk_ev;
    logic enabled;
    logic on_hit;
    logic act_now;
    logic lit;

    always_comb begin
        on_ev          = '0;
        on_ev[EV_2G5]  = link_up && speed == SPD_2G5;
        on_ev[EV_FRC]  = 1'b1;
        on_ev[EV_DN]   = !link_up;
        on_ev[EV_100]  = link_up && speed == SPD_100M;
        on_ev[EV_1G]   = link_up && speed == SPD_1G;

        bk_ev            = '0;
        bk_ev[BK_RX2G5]  = act_rx[SP_2G5];
        bk_ev[BK_TX2G5]  = act_tx[SP_2G5];
        bk_ev[BK_FRC]    = 1'b1;
        bk_ev[BK_RX100]  = act_rx[SP_100];
        bk_ev[BK_TX100]  = act_tx[SP_100];
        bk_ev[BK_RX1G]   = act_rx[SP_1G];
        bk_ev[BK_TX1G]   = act_tx[SP_1G];

        enabled = active && on_cfg[ON_EN];
        on_hit  = |(on_cfg & on_ev);
        act_now = |(blk_cfg & bk_ev);

        s_d = s_q;
        if (!enabled) begin
            s_d.hold  = 1'b0;
            s_d.armed = 1'b0;
        end else if (act_now) begin
            s_d.hold  = 1'b1;
            s_d.armed = 1'b0;
        end else if (period_end && s_q.hold) begin
            if (s_q.armed) begin
                s_d.hold  = 1'b0;
                s_d.armed = 1'b0;
            end else begin
                s_d.armed = 1'b1;
            end
        end

        lit     = enabled && (on_hit || ((act_now || s_q.hold) && wave));
        s_d.led = on_cfg[ON_POL] ? lit : !lit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 3'b001;
        else        s_q <= s_d;
    end

    assign led = s_q.led;

    AST_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enabled |=> (led == !$past(on_cfg[ON_POL]))); // R3
    AST_ON_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && on_hit) |=> (led == $past(on_cfg[ON_POL]))); // R6
    AST_ACT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (enabled && act_now) |=> s_q.hold); // R10
endmodule

// File: rtl/lnk_led_ctrl.sv
module lnk_led_ctrl
    import lel_pkg::*;
#(
    parameter int N_LED    = 3,
    parameter int PRESCALE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              link_up,
    input  logic [1:0]        link_speed,
    input  logic [2:0]        act_tx,
    input  logic [2:0]        act_rx,
    output logic [N_LED-1:0]  led_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic                         ext_en;
    logic [1:0]                   mode;
    logic                         blink_en;
    logic [DATA_W-1:0]            on_time;
    logic [DATA_W-1:0]            period;
    logic [N_LED-1:0][DATA_W-1:0] on_cfg;
    logic [N_LED-1:0][DATA_W-1:0] blk_cfg;
    logic                         wave;
    logic                         period_end;
    logic                         active;
    speed_e                       speed;

    assign active = ext_en && (mode != 2'b00);
    assign speed  = speed_e'(link_speed);

    lel_regs #(.N_LED(N_LED)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ext_en   (ext_en),
        .mode     (mode),
        .blink_en (blink_en),
        .on_time  (on_time),
        .period   (period),
        .on_cfg   (on_cfg),
        .blk_cfg  (blk_cfg)
    );

    lel_timebase #(.PRESCALE(PRESCALE)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .blink_en   (blink_en),
        .on_time    (on_time),
        .period     (period),
        .wave       (wave),
        .period_end (period_end)
    );

    for (genvar g = 0; g < N_LED; g++) begin : g_lane
        lel_lane u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .active     (active),
            .on_cfg     (on_cfg[g]),
            .blk_cfg    (blk_cfg[g]),
            .link_up    (link_up),
            .speed      (speed),
            .act_tx     (act_tx),
            .act_rx     (act_rx),
            .wave       (wave),
            .period_end (period_end),
            .led        (led_o[g])
        );
    end
endmodule

// File: tb/tb_lnk_led_ctrl.sv
module tb_lnk_led_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        link_up = 1'b0;
    logic [1:0]  link_speed = '0;
    logic [2:0]  act_tx = '0;
    logic [2:0]  act_rx = '0;
    logic [2:0]  led_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lnk_led_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .link_up(link_up),
        .link_speed(link_speed), .act_tx(act_tx), .act_rx(act_rx), .led_o(led_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, {16'h0, reg_rdata}, {16'h0, exp});
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic count_hi(input int idx, input int n, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (led_o[idx]) hi++;
        end
    endtask

    function automatic logic on_expect(input int b, input logic up, input logic [1:0] sp);
        case (b)
            8: return up && sp == 2'b10;
            3: return !up;
            1: return up && sp == 2'b00;
            0: return up && sp == 2'b01;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        int hi;
        int bits[4];
        bits = '{8, 3, 1, 0};

        repeat (3) @(negedge clk);
        // R2: reset state
        chk("R2 led reset", {29'h0, led_o}, 32'h7);
        rd_chk("R2 ctl reset", 8'h21, 16'h0000);
        rd_chk("R2 lane reset", 8'h24, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 led after reset release", {29'h0, led_o}, 32'h7);

        // R1: register map and field masks
        wr(8'h21, 16'hFFFF); rd_chk("R1 ctl mask", 8'h21, 16'h800B);
        wr(8'h22, 16'hA5A5); rd_chk("R1 on-time", 8'h22, 16'hA5A5);
        wr(8'h23, 16'h5A5A); rd_chk("R1 period", 8'h23, 16'h5A5A);
        wr(8'h28, 16'hFFFF); rd_chk("R1 steady mask lane2", 8'h28, 16'hC14B);
        wr(8'h29, 16'hFFFF); rd_chk("R1 blink mask lane2", 8'h29, 16'h0E0F);
        wr(8'h2A, 16'hFFFF); rd_chk("R1 unmapped", 8'h2A, 16'h0000);
        rd_chk("R1 lane0 untouched", 8'h24, 16'h0000);
        wr(8'h28, 16'h0000); wr(8'h29, 16'h0000);

        // R3: mode gating, LED0 enabled, active high, forced on
        wr(8'h24, 16'hC040);
        wr(8'h21, 16'h0001); settle();
        chk("R3 no external control", {31'h0, led_o[0]}, 32'h0);
        wr(8'h21, 16'h8000); settle();
        chk("R3 mode zero", {31'h0, led_o[0]}, 32'h0);
        wr(8'h21, 16'h8003); settle();
        chk("R3 mode active", {31'h0, led_o[0]}, 32'h1);

        // R4: enable and polarity
        wr(8'h24, 16'h4040); settle();
        chk("R4 disabled active-high rests 0", {31'h0, led_o[0]}, 32'h0);
        wr(8'h24, 16'h0040); settle();
        chk("R4 disabled active-low rests 1", {31'h0, led_o[0]}, 32'h1);
        wr(8'h24, 16'h8040); settle();
        chk("R4 enabled active-low lit drives 0", {31'h0, led_o[0]}, 32'h0);

        // R5: sweep steady mask bits against link states (blink clock off)
        wr(8'h21, 16'h8001);
        foreach (bits[bi]) begin
            wr(8'h24, 16'hC000 | (16'h1 << bits[bi]));
            wr(8'h26, 16'h8000 | (16'h1 << bits[bi]));
            wr(8'h28, 16'hC000 | (16'h1 << bits[bi]));
            for (int st = 0; st < 5; st++) begin
                logic e;
                @(negedge clk);
                link_up    = (st != 0);
                link_speed = (st == 0) ? 2'b00 : 2'(st - 1);
                settle();
                e = on_expect(bits[bi], link_up, link_speed);
                chk($sformatf("R5 bit%0d state%0d", bits[bi], st),
                    {29'h0, led_o}, {29'h0, e, !e, e});
            end
        end
        @(negedge clk);
        link_up = 1'b1; link_speed = 2'b11;
        wr(8'h26, 16'h0000); wr(8'h28, 16'h0000);

        // R7/R8: blink waveform, PRESCALE 4
        wr(8'h24, 16'hC000); wr(8'h25, 16'h0200);
        wr(8'h22, 16'd2); wr(8'h23, 16'd4);
        wr(8'h21, 16'h8009);
        repeat (4) settle();
        count_hi(0, 64, hi); chk("R7 half duty over 4 periods", hi, 32);
        wr(8'h22, 16'd1); wr(8'h23, 16'd3);
        repeat (20) settle();
        count_hi(0, 48, hi); chk("R8 one tick per 4 cycles", hi, 16);
        wr(8'h22, 16'd0); repeat (2) settle();
        count_hi(0, 48, hi); chk("R7 on-time zero", hi, 0);
        wr(8'h22, 16'd5); wr(8'h23, 16'd4); repeat (20) settle();
        count_hi(0, 48, hi); chk("R7 on-time beyond period", hi, 48);
        wr(8'h22, 16'd2);
        wr(8'h21, 16'h8001); settle();
        count_hi(0, 40, hi);
        chk("R8 frozen phase", (hi == 0 || hi == 40) ? 1 : 0, 1);

        // R6: steady overrides blink
        wr(8'h21, 16'h8009);
        wr(8'h24, 16'hC040); settle();
        count_hi(0, 40, hi); chk("R6 steady over blink", hi, 40);
        wr(8'h24, 16'h0000); wr(8'h25, 16'h0000);

        // R9/R10: activity hold on LED1, 1G transmit only
        wr(8'h26, 16'hC000); wr(8'h27, 16'h0001);
        repeat (40) settle();
        count_hi(1, 16, hi); chk("R10 idle before pulse", hi, 0);
        @(negedge clk); act_tx = 3'b010;
        @(negedge clk); act_tx = 3'b000;
        hi = led_o[1] ? 1 : 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (led_o[1]) hi++;
        end
        chk("R10 one full period after pulse", hi, 8);
        repeat (40) settle();
        count_hi(1, 32, hi); chk("R10 stops within two periods", hi, 0);
        @(negedge clk); act_rx = 3'b100; act_tx = 3'b001;
        @(negedge clk); act_rx = 3'b000; act_tx = 3'b000;
        count_hi(1, 40, hi); chk("R9 unselected activity ignored", hi, 0);
        wr(8'h27, 16'h0800);
        @(negedge clk); act_rx = 3'b100;
        @(negedge clk); act_rx = 3'b000;
        hi = led_o[1] ? 1 : 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (led_o[1]) hi++;
        end
        chk("R9 2.5G receive selected", hi, 8);

        // R11: one-cycle output latency
        repeat (40) settle();
        wr(8'h21, 16'h8001);
        @(negedge clk); reg_we = 1'b1; reg_addr = 8'h26; reg_wdata = 16'hC040;
        @(posedge clk); #1;
        reg_we = 1'b0;
        chk("R11 not yet lit at write edge", {31'h0, led_o[1]}, 32'h0);
        @(posedge clk); #1;
        chk("R11 lit one clock later", {31'h0, led_o[1]}, 32'h1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule